// File: doc/BRIEF.md
# Stable Counting-Sort Radix Pass

This block carries out a single digit pass of a least-significant-digit-first radix sort. A block of keys sits in a local RAM. The block reads that RAM through a synchronous read port, and it writes every key to a destination RAM at its sorted slot. A full sort runs one pass per digit: the lowest digit first, then the next one up. Because every pass is stable, the passes compose, and the result after the top digit is fully ascending.

Each pass runs four phases in turn:

1. Zero the on-chip count RAM, one bin per cycle.
2. Histogram the selected digit over all keys.
3. Rewrite each bin in place as the exclusive running total of the bins below it.
4. Walk the keys again in input order. Each key goes to the offset of its digit, and that offset is then post-incremented.

The count RAM has one cycle of read latency. A key whose digit equals the digit of the key just before it would therefore read a stale count. The block resolves this by forwarding the count it has just written.

The digit width is a parameter. Any width works as long as the count RAM (two to the power of the digit width entries) fits the target. Wider digits need fewer passes.

Top module: `radix_pass`

## Requirements
- R1: After reset, `done`, `wr_en` and `key_rd_en` are all low, and the block waits for `start`.
- R2: A `start` seen while idle latches `digit_sel`. Digit d of a key is the field `key[d*DIGIT_W +: DIGIT_W]`, so digit 0 is the least significant field.
- R3: Each key is written to the slot equal to the number of keys with a smaller digit, plus the number of earlier keys (lower read address) with the same digit. This makes the pass stable. A pass does not depend on the counts left by an earlier pass.
- R4: A pass makes exactly N_KEYS writes, in ascending input order, with all addresses distinct.
- R5: Consecutive keys that share a digit land in consecutive slots, in order. This includes a block where every key has the same digit.
- R6: `done` is a one-cycle pulse that follows the last write. `wr_en` is low in the cycle of `done`.
- R7: A `start` that arrives while a pass is running has no effect on that pass, including its digit selection.
- R8: A pass reads each key address exactly twice. Each read burst presents ascending addresses, one per cycle.
- R9: Running passes for digits 0 up to the top digit, each pass using the previous pass's output as its input, leaves the keys in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (honoured only when idle) |
| digit_sel | input | SEL_W | Index of the digit this pass sorts on |
| key_rd_en | output | 1 | Key RAM read strobe |
| key_rd_addr | output | ADDR_W | Key RAM read address |
| key_rd_data | input | KEY_W | Key RAM data, valid one cycle after the strobe |
| wr_en | output | 1 | Destination RAM write strobe |
| wr_addr | output | ADDR_W | Destination slot of the key |
| wr_data | output | KEY_W | Key being placed |
| done | output | 1 | One-cycle pulse at the end of the pass |

## Verification
A corrupted bin count cannot hide. It shows up at the destination port during the scatter phase of the same pass, as a wrong or repeated slot address, and that error lands in the very cycle the affected key is written. A lost forwarding update shows up as two equal-digit neighbours writing the same slot, which is why a block in which every key has the same digit is run. A bin that was not cleared only shows on a second pass, so passes are always run back to back. A wrongly latched digit index scrambles the whole output order.

// File: rtl/radix_pkg.sv
package radix_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CLEAR   = 3'd1,
        PH_HIST    = 3'd2,
        PH_PREFIX  = 3'd3,
        PH_SCATTER = 3'd4
    } pass_phase_e;

endpackage

// File: rtl/radix_digit_ext.sv
module radix_digit_ext #(
    parameter int KEY_W   = 16,
    parameter int DIGIT_W = 4,
    parameter int SEL_W   = 2
) (
    input  logic [KEY_W-1:0]   key_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [DIGIT_W-1:0] digit_o
);

    logic [KEY_W-1:0] shifted;

    always_comb begin
        shifted = key_i >> (int'(sel_i) * DIGIT_W);
        digit_o = shifted[DIGIT_W-1:0];
    end

endmodule

// File: rtl/radix_count_ram.sv
module radix_count_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // read-before-write: a read of the address being written returns the old value
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/radix_pass.sv
module radix_pass
    import radix_pkg::*;
#(
    parameter int KEY_W   = 16,
    parameter int DIGIT_W = 4,
    parameter int N_KEYS  = 16,
    localparam int N_DIG  = KEY_W / DIGIT_W,
    localparam int SEL_W  = (N_DIG > 1) ? $clog2(N_DIG) : 1,
    localparam int ADDR_W = $clog2(N_KEYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEL_W-1:0]  digit_sel,
    output logic              key_rd_en,
    output logic [ADDR_W-1:0] key_rd_addr,
    input  logic [KEY_W-1:0]  key_rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [KEY_W-1:0]  wr_data,
    output logic              done
);

    localparam int BINS  = 2 ** DIGIT_W;
    localparam int CW    = $clog2(N_KEYS + 1);
    localparam int SPAN  = (N_KEYS > BINS) ? N_KEYS : BINS;
    localparam int IW    = $clog2(SPAN + 1);

    typedef struct packed {
        pass_phase_e          phase;
        logic [IW-1:0]        idx;
        logic [SEL_W-1:0]     sel;
        logic                 a_vld;
        logic                 b_vld;
        logic [DIGIT_W-1:0]   b_digit;
        logic [KEY_W-1:0]     b_key;
        logic                 fwd_vld;
        logic [DIGIT_W-1:0]   fwd_addr;
        logic [CW-1:0]        fwd_data;
        logic [CW-1:0]        sum;
        logic                 done;
    } pass_st_t;

    pass_st_t st_d, st_q;

    logic [DIGIT_W-1:0] key_digit;
    logic               cnt_we;
    logic [DIGIT_W-1:0] cnt_waddr;
    logic [CW-1:0]      cnt_wdata;
    logic [DIGIT_W-1:0] cnt_raddr;
    logic [CW-1:0]      cnt_rdata;
    logic [CW-1:0]      cnt_cur;
    logic [CW-1:0]      cnt_inc;

    radix_digit_ext #(
        .KEY_W   (KEY_W),
        .DIGIT_W (DIGIT_W),
        .SEL_W   (SEL_W)
    ) u_digit (
        .key_i   (key_rd_data),
        .sel_i   (st_q.sel),
        .digit_o (key_digit)
    );

    radix_count_ram #(
        .ADDR_W (DIGIT_W),
        .DATA_W (CW)
    ) u_cnt (
        .clk   (clk),
        .we    (cnt_we),
        .waddr (cnt_waddr),
        .wdata (cnt_wdata),
        .raddr (cnt_raddr),
        .rdata (cnt_rdata)
    );

    // the RAM output is stale when the previous key updated the same bin
    always_comb begin
        cnt_cur = (st_q.fwd_vld && (st_q.fwd_addr == st_q.b_digit)) ? st_q.fwd_data : cnt_rdata;
        cnt_inc = cnt_cur + CW'(1);
    end

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.a_vld  = 1'b0;
        st_d.b_vld  = 1'b0;
        key_rd_en   = 1'b0;
        key_rd_addr = st_q.idx[ADDR_W-1:0];
        cnt_raddr   = key_digit;
        cnt_we      = 1'b0;
        cnt_waddr   = st_q.b_digit;
        cnt_wdata   = cnt_inc;
        wr_en       = 1'b0;
        wr_addr     = cnt_cur[ADDR_W-1:0];
        wr_data     = st_q.b_key;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_CLEAR;
                    st_d.idx     = '0;
                    st_d.sel     = digit_sel;
                    st_d.fwd_vld = 1'b0;
                end
            end

            PH_CLEAR: begin
                cnt_we    = 1'b1;
                cnt_waddr = st_q.idx[DIGIT_W-1:0];
                cnt_wdata = '0;
                st_d.idx  = st_q.idx + IW'(1);
                if (st_q.idx == IW'(BINS - 1)) begin
                    st_d.phase = PH_HIST;
                    st_d.idx   = '0;
                end
            end

            PH_HIST, PH_SCATTER: begin
                if (st_q.idx != IW'(N_KEYS)) begin
                    key_rd_en  = 1'b1;
                    st_d.idx   = st_q.idx + IW'(1);
                    st_d.a_vld = 1'b1;
                end
                st_d.b_vld   = st_q.a_vld;
                st_d.b_digit = key_digit;
                st_d.b_key   = key_rd_data;
                st_d.fwd_vld = st_q.b_vld;
                if (st_q.b_vld) begin
                    cnt_we        = 1'b1;
                    st_d.fwd_addr = st_q.b_digit;
                    st_d.fwd_data = cnt_inc;
                    wr_en         = (st_q.phase == PH_SCATTER);
                end
                if (st_q.idx == IW'(N_KEYS) && !st_q.a_vld && !st_q.b_vld) begin
                    st_d.idx     = '0;
                    st_d.fwd_vld = 1'b0;
                    if (st_q.phase == PH_HIST) begin
                        st_d.phase = PH_PREFIX;
                        st_d.sum   = '0;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end

            PH_PREFIX: begin
                cnt_raddr = st_q.idx[DIGIT_W-1:0];
                if (st_q.idx != IW'(BINS)) begin
                    st_d.idx     = st_q.idx + IW'(1);
                    st_d.b_vld   = 1'b1;
                    st_d.b_digit = st_q.idx[DIGIT_W-1:0];
                end
                if (st_q.b_vld) begin
                    cnt_we    = 1'b1;
                    cnt_wdata = st_q.sum;
                    st_d.sum  = st_q.sum + cnt_rdata;
                end
                if (st_q.idx == IW'(BINS) && !st_q.b_vld) begin
                    st_d.phase   = PH_SCATTER;
                    st_d.idx     = '0;
                    st_d.fwd_vld = 1'b0;
                end
            end

            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;

endmodule

// File: rtl/radix_pass_chk.sv
module radix_pass_chk #(
    parameter int N_KEYS = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              wr_en,
    input logic              key_rd_en,
    input logic [ADDR_W-1:0] key_rd_addr
);

    localparam int WCW = $clog2(N_KEYS + 1) + 1;

    logic [WCW-1:0] wr_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt_q <= '0;
        end else if (done) begin
            wr_cnt_q <= '0;
        end else if (wr_en) begin
            wr_cnt_q <= wr_cnt_q + WCW'(1);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_NO_WR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en); // R6

    AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_cnt_q == WCW'(N_KEYS))); // R4

    AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (key_rd_en && $past(key_rd_en)) |-> (key_rd_addr == ADDR_W'($past(key_rd_addr) + 1'b1))); // R8

endmodule

bind radix_pass radix_pass_chk #(
    .N_KEYS (N_KEYS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .wr_en       (wr_en),
    .key_rd_en   (key_rd_en),
    .key_rd_addr (key_rd_addr)
);

// File: tb/tb_radix_pass.sv
module tb_radix_pass;

    localparam int KEY_W   = 16;
    localparam int DIGIT_W = 4;
    localparam int N_KEYS  = 16;
    localparam int N_DIG   = KEY_W / DIGIT_W;
    localparam int SEL_W   = $clog2(N_DIG);
    localparam int ADDR_W  = $clog2(N_KEYS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [SEL_W-1:0]  digit_sel = '0;
    logic              key_rd_en;
    logic [ADDR_W-1:0] key_rd_addr;
    logic [KEY_W-1:0]  key_rd_data = '0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [KEY_W-1:0]  wr_data;
    logic              done;

    logic [KEY_W-1:0] key_mem [N_KEYS];
    logic [KEY_W-1:0] out_mem [N_KEYS];
    logic [KEY_W-1:0] exp_out [N_KEYS];
    int               exp_addr_q [$];
    logic [KEY_W-1:0] exp_data_q [$];

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    int    rd_cnt = 0;
    string cur_req = "R3";

    always #4 clk = ~clk;

    radix_pass #(
        .KEY_W   (KEY_W),
        .DIGIT_W (DIGIT_W),
        .N_KEYS  (N_KEYS)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .digit_sel   (digit_sel),
        .key_rd_en   (key_rd_en),
        .key_rd_addr (key_rd_addr),
        .key_rd_data (key_rd_data),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .done        (done)
    );

    always @(posedge clk) begin
        if (key_rd_en) key_rd_data <= key_mem[key_rd_addr];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // reference: every write compared against the stable-order model
    always @(negedge clk) begin
        if (rst_n) begin
            if (key_rd_en) rd_cnt++;
            if (wr_en) begin
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, "R4 extra write", longint'(wr_addr), -1);
                end else begin
                    int ea;
                    logic [KEY_W-1:0] ed;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    check(int'(wr_addr) == ea && wr_data == ed, cur_req,
                          {32'(wr_addr), 16'h0, wr_data}, {32'(ea), 16'h0, ed});
                end
                out_mem[wr_addr] = wr_data;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int digit_of(input logic [KEY_W-1:0] k, input int d);
        return int'((k >> (d * DIGIT_W)) & ((1 << DIGIT_W) - 1));
    endfunction

    task automatic run_pass(input int d, input bit intrude, input string req);
        int ia;
        int ib;
        int pos;
        cur_req = req;
        for (int k = 0; k < N_KEYS; k++) begin
            ia = digit_of(key_mem[k], d);
            pos = 0;
            for (int j = 0; j < N_KEYS; j++) begin
                ib = digit_of(key_mem[j], d);
                if (ib < ia || (ib == ia && j < k)) pos++;
            end
            exp_addr_q.push_back(pos);
            exp_data_q.push_back(key_mem[k]);
            exp_out[pos] = key_mem[k];
        end
        for (int k = 0; k < N_KEYS; k++) out_mem[k] = 16'hDEAD;
        rd_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        digit_sel = SEL_W'(d);
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            digit_sel = SEL_W'(d + 1);
            @(negedge clk);
            start = 1'b0;
            repeat (12) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check(exp_addr_q.size() == 0, "R4 missing writes", exp_addr_q.size(), 0);
        exp_addr_q.delete();
        exp_data_q.delete();
        check(!wr_en, "R6 write at done", wr_en, 0);
        check(rd_cnt == 2 * N_KEYS, "R8 read count", rd_cnt, 2 * N_KEYS);
        for (int k = 0; k < N_KEYS; k++) begin
            check(out_mem[k] == exp_out[k], req, out_mem[k], exp_out[k]);
        end
        @(negedge clk);
        check(!done, "R6 done pulse width", done, 0);
        check(!wr_en, "R6 no write after done", wr_en, 0);
    endtask

    initial begin
        logic [KEY_W-1:0] srt [N_KEYS];
        logic [KEY_W-1:0] t;
        repeat (3) @(negedge clk);
        check(!done && !wr_en && !key_rd_en, "R1 reset outputs",
              {done, wr_en, key_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !wr_en && !key_rd_en, "R1 idle outputs",
              {done, wr_en, key_rd_en}, 0);

        // random keys, lowest digit (R3, R2)
        for (int k = 0; k < N_KEYS; k++) key_mem[k] = KEY_W'($urandom);
        run_pass(0, 1'b0, "R3");
        // same keys, upper digit field (R2)
        run_pass(2, 1'b0, "R2");
        run_pass(3, 1'b0, "R2");

        // every key shares digit 0: forwarding on each step (R5)
        for (int k = 0; k < N_KEYS; k++) key_mem[k] = KEY_W'((k * 16'h0130) | 16'h0005);
        run_pass(0, 1'b0, "R5");

        // alternating pairs of equal digits (R5)
        for (int k = 0; k < N_KEYS; k++) key_mem[k] = KEY_W'(((k / 2) % 2 == 0 ? 9 : 2) | (k << 8));
        run_pass(0, 1'b0, "R5");

        // descending digits (R3)
        for (int k = 0; k < N_KEYS; k++) key_mem[k] = KEY_W'(((N_KEYS - 1 - k) << 4) | k);
        run_pass(1, 1'b0, "R3");

        // start pulses during a pass are ignored (R7)
        for (int k = 0; k < N_KEYS; k++) key_mem[k] = KEY_W'($urandom);
        run_pass(1, 1'b1, "R7");

        // full LSD sort by chaining passes (R9)
        for (int k = 0; k < N_KEYS; k++) begin
            key_mem[k] = KEY_W'($urandom);
            srt[k] = key_mem[k];
        end
        for (int i = 1; i < N_KEYS; i++) begin
            for (int j = i; j > 0 && srt[j-1] > srt[j]; j--) begin
                t = srt[j]; srt[j] = srt[j-1]; srt[j-1] = t;
            end
        end
        for (int p = 0; p < N_DIG; p++) begin
            run_pass(p, 1'b0, "R9 pass");
            for (int k = 0; k < N_KEYS; k++) key_mem[k] = out_mem[k];
        end
        for (int k = 0; k < N_KEYS; k++) begin
            check(key_mem[k] == srt[k], "R9 final order", key_mem[k], srt[k]);
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule